// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block decides where a processor goes when it takes an exception. One cycle carries an exception request. With it come a kind code, a flag that marks a page-table refill miss, a flag that marks an instruction in a branch delay slot, and the program counter of the faulting instruction. The same cycle also carries a snapshot of the status and interrupt state: the exception-level bit, the boot-vector bit, the interrupt-vector enable, the vector spacing, the pending and mask lines, and the programmable exception base.

From these inputs the block produces the handler address, the return address and the five-bit cause code. It also produces one write strobe for each piece of architectural state that the entry changes: exception PC, error PC, delay-slot bit, exception level, error level, boot-vector bit, cause code and the forced return to kernel mode. The register file next to it applies those strobes.

All results are registered. They appear in the cycle after the request, together with a single-cycle acknowledge. The data outputs keep their last values between requests. The strobes are high only in the acknowledge cycle.

Top module: `exc_vector_ctrl`

## Requirements
- R1: `ack` is high exactly in the cycle after a cycle with `req_valid` high. Every write strobe is low in any cycle without `ack`. After reset, `ack`, all strobes and `handler_pc` are zero.
- R2: The vector base is 0xBFC00200 when `st_bev` is 1. Otherwise it is `exc_base` with bits 9:0 cleared. An ordinary exception jumps to base + 0x180.
- R3: A TLB load (kind 2) or TLB store (kind 3) request with `req_refill` = 1 and `st_exl` = 0 jumps to base + 0x000. If `st_exl` = 1, the same request jumps to base + 0x180.
- R4: An interrupt (kind 0) jumps to base + 0x180 when `cause_iv` = 0. It jumps to base + 0x200 when `cause_iv` = 1 and either `st_bev` = 1 or `int_spacing` = 0.
- R5: When `cause_iv` = 1, `st_bev` = 0 and `int_spacing` is not zero, an interrupt jumps to base + 0x200 + v × (`int_spacing` × 32). Here v is the index of the highest set bit of `int_pending` & `int_mask`, and v is 0 when none is set.
- R6: A cache error (kind 30) jumps to base + 0x100 when `st_bev` = 1 and to base + 0x20000100 otherwise.
- R7: For a kind other than 28 or 29 taken with `st_exl` = 0, `epc_we`, `bd_we`, `exl_set` and `ksu_clear` are 1. With `st_exl` = 1 all four are 0.
- R8: `ret_pc` is `req_pc` − 4 and `bd_val` is 1 when `req_in_slot` = 1. Otherwise `ret_pc` is `req_pc` and `bd_val` is 0.
- R9: The kind field is the cause code itself: interrupt 0, modify 1, TLB load 2, TLB store 3, address load 4, address store 5, instruction bus 6, data bus 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, read-inhibit 19, execute-inhibit 20, cache error 30. For every such kind, `cause_we` = 1 and `exc_code` equals the kind, whatever the value of `st_exl`.
- R10: Kind 28 (non-maskable interrupt) and kind 29 (soft reset) jump to 0xBFC00000. They assert `errepc_we`, `erl_set`, `bev_set` and `ksu_clear`, and leave `epc_we`, `exl_set`, `bd_we` and `cause_we` low, whatever the value of `st_exl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request this cycle |
| req_kind | input | 5 | Exception kind, equal to cause code (28/29 reset class) |
| req_refill | input | 1 | TLB fault was a no-match refill |
| req_in_slot | input | 1 | Faulting instruction is in a delay slot |
| req_pc | input | 32 | PC of the faulting instruction |
| st_exl | input | 1 | Exception level currently set |
| st_bev | input | 1 | Boot exception vectors selected |
| cause_iv | input | 1 | Dedicated interrupt vector enable |
| int_spacing | input | 5 | Vector spacing field |
| int_pending | input | 8 | Pending interrupt lines |
| int_mask | input | 8 | Interrupt mask bits |
| exc_base | input | 32 | Programmable exception base |
| ack | output | 1 | Entry results valid (one-cycle pulse) |
| handler_pc | output | 32 | Handler address |
| ret_pc | output | 32 | Return address to save |
| epc_we | output | 1 | Write `ret_pc` into exception PC |
| errepc_we | output | 1 | Write `ret_pc` into error PC |
| bd_we | output | 1 | Write the delay-slot bit |
| bd_val | output | 1 | Delay-slot bit value |
| exl_set | output | 1 | Set exception level |
| erl_set | output | 1 | Set error level |
| bev_set | output | 1 | Set boot-vector bit |
| cause_we | output | 1 | Write `exc_code` into cause |
| exc_code | output | 5 | Cause code |
| ksu_clear | output | 1 | Clear user/supervisor bits |

## Verification
A wrong priority pick or a wrong spacing scale in the interrupt vector logic shows up directly as a wrong `handler_pc` in the acknowledge cycle, one clock after the request. A mishandled exception-level snapshot shows up in the same cycle as a strobe of `epc_we` or `exl_set` that should not be there, and a nested exception would then corrupt the saved return address. A refill request taken under `st_exl` that still gets the zero offset gives a `handler_pc` that is 0x180 too low. All of these appear in that one cycle, because the block holds no state beyond the output register.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] K_INT   = 5'd0;
  localparam logic [CODE_W-1:0] K_TLBL  = 5'd2;
  localparam logic [CODE_W-1:0] K_TLBS  = 5'd3;
  localparam logic [CODE_W-1:0] K_NMI   = 5'd28;
  localparam logic [CODE_W-1:0] K_SRST  = 5'd29;
  localparam logic [CODE_W-1:0] K_CACHE = 5'd30;

  localparam logic [31:0] BOOT_BASE   = 32'hBFC0_0200;
  localparam logic [31:0] RESET_VEC   = 32'hBFC0_0000;
  localparam logic [31:0] OFF_GENERAL = 32'h0000_0180;
  localparam logic [31:0] OFF_REFILL  = 32'h0000_0000;
  localparam logic [31:0] OFF_IRQ     = 32'h0000_0200;
  localparam logic [31:0] OFF_CERR_B  = 32'h0000_0100;
  localparam logic [31:0] OFF_CERR_N  = 32'h2000_0100;

  typedef struct packed {
    logic epc_we;
    logic errepc_we;
    logic bd_we;
    logic exl_set;
    logic erl_set;
    logic bev_set;
    logic cause_we;
    logic ksu_clear;
  } strobe_t;

  function automatic logic is_reset_class(input logic [CODE_W-1:0] k);
    return (k == K_NMI) || (k == K_SRST);
  endfunction
endpackage

// File: rtl/exc_irq_vector.sv
module exc_irq_vector #(
  parameter int LINES = 8,
  parameter int SP_W  = 5,
  parameter int OFF_W = 32
) (
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] mask,
  input  logic [SP_W-1:0]  spacing,
  input  logic             bev,
  input  logic             iv,
  output logic [OFF_W-1:0] offset,
  output logic [$clog2(LINES)-1:0] vec_idx
);
  import exc_vec_pkg::*;
  localparam int IDX_W = $clog2(LINES);
  localparam int STEP_SHIFT = 5;

  function automatic logic [IDX_W-1:0] top_index(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LINES; i++) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [OFF_W-1:0] spaced_off(input logic [IDX_W-1:0] idx,
                                                  input logic [SP_W-1:0] sp);
    return OFF_W'(OFF_IRQ) + OFF_W'(idx) * (OFF_W'(sp) << STEP_SHIFT);
  endfunction

  logic [LINES-1:0] live;
  assign live    = pending & mask;
  assign vec_idx = top_index(live);

  always_comb begin
    if (!iv)                        offset = OFF_W'(OFF_GENERAL);
    else if (bev || spacing == '0)  offset = OFF_W'(OFF_IRQ);
    else                            offset = spaced_off(vec_idx, spacing);
  end

  // R5
  always_comb begin
    vec_top_chk: assert (live == '0 || live[vec_idx])
      else $error("selected vector line is not live");
  end
endmodule

// File: rtl/exc_offset_sel.sv
module exc_offset_sel #(
  parameter int OFF_W = 32
) (
  input  logic [4:0]       kind,
  input  logic             refill,
  input  logic             exl,
  input  logic             bev,
  input  logic [OFF_W-1:0] irq_off,
  output logic [OFF_W-1:0] offset
);
  import exc_vec_pkg::*;

  logic tlb_kind;
  assign tlb_kind = (kind == K_TLBL) || (kind == K_TLBS);

  always_comb begin
    if (kind == K_INT)                      offset = irq_off;
    else if (kind == K_CACHE)               offset = bev ? OFF_W'(OFF_CERR_B) : OFF_W'(OFF_CERR_N);
    else if (tlb_kind && refill && !exl)    offset = OFF_W'(OFF_REFILL);
    else                                    offset = OFF_W'(OFF_GENERAL);
  end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exc_vec_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IRQ_LINES  = 8,
  parameter int SPACE_W    = 5,
  parameter int BASE_ALIGN = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CODE_W-1:0]    req_kind,
  input  logic                 req_refill,
  input  logic                 req_in_slot,
  input  logic [PC_W-1:0]      req_pc,
  input  logic                 st_exl,
  input  logic                 st_bev,
  input  logic                 cause_iv,
  input  logic [SPACE_W-1:0]   int_spacing,
  input  logic [IRQ_LINES-1:0] int_pending,
  input  logic [IRQ_LINES-1:0] int_mask,
  input  logic [PC_W-1:0]      exc_base,
  output logic                 ack,
  output logic [PC_W-1:0]      handler_pc,
  output logic [PC_W-1:0]      ret_pc,
  output logic                 epc_we,
  output logic                 errepc_we,
  output logic                 bd_we,
  output logic                 bd_val,
  output logic                 exl_set,
  output logic                 erl_set,
  output logic                 bev_set,
  output logic                 cause_we,
  output logic [CODE_W-1:0]    exc_code,
  output logic                 ksu_clear
);
  localparam int IDX_W = $clog2(IRQ_LINES);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~((PC_W'(1) << BASE_ALIGN) - PC_W'(1));
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  // named internal events
  logic             reset_class;
  logic             first_entry;
  logic [PC_W-1:0]  vec_base;
  logic [PC_W-1:0]  irq_off;
  logic [PC_W-1:0]  sel_off;
  logic [IDX_W-1:0] irq_idx;
  logic [PC_W-1:0]  nxt_handler;
  logic [PC_W-1:0]  nxt_ret;
  strobe_t          nxt_strb;
  strobe_t          strb_q;

  exc_irq_vector #(.LINES(IRQ_LINES), .SP_W(SPACE_W), .OFF_W(PC_W)) u_irq (
    .pending (int_pending),
    .mask    (int_mask),
    .spacing (int_spacing),
    .bev     (st_bev),
    .iv      (cause_iv),
    .offset  (irq_off),
    .vec_idx (irq_idx)
  );

  exc_offset_sel #(.OFF_W(PC_W)) u_off (
    .kind    (req_kind),
    .refill  (req_refill),
    .exl     (st_exl),
    .bev     (st_bev),
    .irq_off (irq_off),
    .offset  (sel_off)
  );

  assign reset_class = is_reset_class(req_kind);
  assign first_entry = !reset_class && !st_exl;
  assign vec_base    = st_bev ? PC_W'(BOOT_BASE) : (exc_base & ALIGN_MASK);
  assign nxt_handler = reset_class ? PC_W'(RESET_VEC) : vec_base + sel_off;
  assign nxt_ret     = req_in_slot ? req_pc - INSN_BYTES : req_pc;

  always_comb begin
    nxt_strb.epc_we    = first_entry;
    nxt_strb.bd_we     = first_entry;
    nxt_strb.exl_set   = first_entry;
    nxt_strb.errepc_we = reset_class;
    nxt_strb.erl_set   = reset_class;
    nxt_strb.bev_set   = reset_class;
    nxt_strb.cause_we  = !reset_class;
    nxt_strb.ksu_clear = reset_class || first_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack        <= 1'b0;
      strb_q     <= '0;
      handler_pc <= '0;
      ret_pc     <= '0;
      bd_val     <= 1'b0;
      exc_code   <= '0;
    end else begin
      ack    <= req_valid;
      strb_q <= req_valid ? nxt_strb : '0;
      if (req_valid) begin
        handler_pc <= nxt_handler;
        ret_pc     <= nxt_ret;
        bd_val     <= req_in_slot;
        exc_code   <= req_kind;
      end
    end
  end

  assign epc_we    = strb_q.epc_we;
  assign errepc_we = strb_q.errepc_we;
  assign bd_we     = strb_q.bd_we;
  assign exl_set   = strb_q.exl_set;
  assign erl_set   = strb_q.erl_set;
  assign bev_set   = strb_q.bev_set;
  assign cause_we  = strb_q.cause_we;
  assign ksu_clear = strb_q.ksu_clear;

  // R1
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ack);
  // R1
  strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (strb_q == '0));
  // R7
  nested_no_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && st_exl |=> !epc_we && !exl_set);
  // R8
  ret_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ret_pc == ($past(req_in_slot) ? $past(req_pc) - INSN_BYTES : $past(req_pc)));
  // R10
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errepc_we |-> handler_pc == PC_W'(RESET_VEC) && !cause_we && !epc_we);
  // R10
  one_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({epc_we, errepc_we}) <= 1);
endmodule

// File: tb/exc_vector_ctrl_tb.sv
`timescale 1ns/1ps
module exc_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_kind = '0;
  logic        req_refill = 1'b0;
  logic        req_in_slot = 1'b0;
  logic [31:0] req_pc = '0;
  logic        st_exl = 1'b0;
  logic        st_bev = 1'b0;
  logic        cause_iv = 1'b0;
  logic [4:0]  int_spacing = '0;
  logic [7:0]  int_pending = '0;
  logic [7:0]  int_mask = '0;
  logic [31:0] exc_base = '0;
  logic        ack;
  logic [31:0] handler_pc, ret_pc;
  logic        epc_we, errepc_we, bd_we, bd_val, exl_set, erl_set, bev_set, cause_we, ksu_clear;
  logic [4:0]  exc_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_refill(req_refill), .req_in_slot(req_in_slot), .req_pc(req_pc),
    .st_exl(st_exl), .st_bev(st_bev), .cause_iv(cause_iv), .int_spacing(int_spacing),
    .int_pending(int_pending), .int_mask(int_mask), .exc_base(exc_base),
    .ack(ack), .handler_pc(handler_pc), .ret_pc(ret_pc), .epc_we(epc_we),
    .errepc_we(errepc_we), .bd_we(bd_we), .bd_val(bd_val), .exl_set(exl_set),
    .erl_set(erl_set), .bev_set(bev_set), .cause_we(cause_we), .exc_code(exc_code),
    .ksu_clear(ksu_clear)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected handler address, built from the requirement text
  function automatic logic [31:0] exp_handler(input logic [4:0] k, input logic refill,
      input logic exl, input logic bev, input logic iv, input logic [4:0] sp,
      input logic [7:0] pend, input logic [7:0] msk, input logic [31:0] base);
    logic [31:0] b, off;
    int v;
    if (k == 5'd28 || k == 5'd29) return 32'hBFC00000;
    b = bev ? 32'hBFC00200 : {base[31:10], 10'b0};
    if (k == 5'd0) begin
      if (!iv) off = 32'h180;
      else if (bev || sp == 0) off = 32'h200;
      else begin
        v = 0;
        for (int i = 7; i >= 0; i--) if (pend[i] && msk[i]) begin v = i; break; end
        off = 32'h200 + 32'(v) * (32'(sp) * 32);
      end
    end else if (k == 5'd30) off = bev ? 32'h100 : 32'h20000100;
    else if ((k == 5'd2 || k == 5'd3) && refill && !exl) off = 32'h0;
    else off = 32'h180;
    return b + off;
  endfunction

  task automatic entry(input logic [4:0] k, input logic refill, input logic slot,
      input logic [31:0] pc, input logic exl, input logic bev, input logic iv,
      input logic [4:0] sp, input logic [7:0] pend, input logic [7:0] msk,
      input logic [31:0] base, input string tag);
    logic rc, first;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_refill = refill; req_in_slot = slot;
    req_pc = pc; st_exl = exl; st_bev = bev; cause_iv = iv; int_spacing = sp;
    int_pending = pend; int_mask = msk; exc_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    rc = (k == 5'd28 || k == 5'd29);
    first = !rc && !exl;
    chk({tag, " R1 ack"}, 32'(ack), 32'd1);
    chk({tag, " R2-R6 handler_pc"}, handler_pc,
        exp_handler(k, refill, exl, bev, iv, sp, pend, msk, base));
    chk({tag, " R8 ret_pc"}, ret_pc, slot ? pc - 32'd4 : pc);
    chk({tag, " R8 bd_val"}, 32'(bd_val), 32'(slot));
    chk({tag, " R7 first-entry strobes"}, {28'd0, epc_we, bd_we, exl_set, ksu_clear & !rc},
        {28'd0, first, first, first, first});
    chk({tag, " R10 reset-class strobes"}, {28'd0, errepc_we, erl_set, bev_set, ksu_clear & rc},
        {28'd0, rc, rc, rc, rc});
    chk({tag, " R9 cause_we"}, 32'(cause_we), 32'(!rc));
    if (!rc) chk({tag, " R9 exc_code"}, 32'(exc_code), 32'(k));
    @(negedge clk);
    chk({tag, " R1 ack pulse ends"}, {30'd0, ack, epc_we | errepc_we | cause_we | ksu_clear}, 32'd0);
  endtask

  logic [4:0] kinds [19] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
                             5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd19, 5'd20, 5'd30, 5'd28};

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ack", 32'(ack), 32'd0);
    chk("R1 reset handler_pc", handler_pc, 32'd0);
    chk("R1 reset strobes", {24'd0, epc_we, errepc_we, bd_we, exl_set, erl_set, bev_set, cause_we, ksu_clear}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    entry(5'd8, 0, 0, 32'h8000_1000, 0, 0, 0, 0, 0, 0, 32'h8123_4567, "R2 syscall base align");
    entry(5'd10, 0, 1, 32'h8000_2004, 0, 1, 0, 0, 0, 0, 32'h0, "R2 R8 bev slot");
    entry(5'd2, 1, 0, 32'h0040_0000, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R3 refill load");
    entry(5'd3, 1, 0, 32'h0040_0000, 0, 1, 0, 0, 0, 0, 32'h8000_0000, "R3 refill store bev");
    entry(5'd2, 1, 0, 32'h0040_0000, 1, 0, 0, 0, 0, 0, 32'h8000_0000, "R3 R7 refill under exl");
    entry(5'd0, 0, 0, 32'h100, 0, 0, 0, 5'd4, 8'hFF, 8'hFF, 32'h8000_0000, "R4 iv clear");
    entry(5'd0, 0, 0, 32'h100, 0, 1, 1, 5'd4, 8'hFF, 8'hFF, 32'h8000_0000, "R4 iv bev");
    entry(5'd0, 0, 0, 32'h100, 0, 0, 1, 5'd0, 8'hFF, 8'hFF, 32'h8000_0000, "R4 spacing zero");
    entry(5'd0, 0, 0, 32'h100, 0, 0, 1, 5'd31, 8'hFF, 8'h80, 32'h8000_0000, "R5 line7 max spacing");
    entry(5'd0, 0, 0, 32'h100, 0, 0, 1, 5'd1, 8'h0F, 8'hF0, 32'h8000_0000, "R5 none live");
    entry(5'd0, 0, 0, 32'h100, 0, 0, 1, 5'd2, 8'h26, 8'h3F, 32'h8000_0000, "R5 line5 wins");
    entry(5'd30, 0, 0, 32'h200, 0, 1, 0, 0, 0, 0, 32'h8000_0000, "R6 cache bev");
    entry(5'd30, 0, 0, 32'h200, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R6 cache normal");
    entry(5'd28, 0, 1, 32'h300, 1, 0, 0, 0, 0, 0, 32'h8000_0000, "R10 nmi under exl");
    entry(5'd29, 0, 0, 32'h304, 0, 0, 0, 0, 0, 0, 32'h8000_0000, "R10 soft reset");
    entry(5'd13, 0, 0, 32'h400, 1, 0, 0, 0, 0, 0, 32'h8000_0000, "R7 R9 trap nested");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] k;
      k = kinds[$urandom_range(0, 18)];
      if (k == 5'd28 && $urandom_range(0, 1) == 1) k = 5'd29;
      entry(k, 1'($urandom()), 1'($urandom()), {$urandom()} & 32'hFFFF_FFFC,
            1'($urandom()), 1'($urandom()), 1'($urandom()), 5'($urandom()),
            8'($urandom()), 8'($urandom()), $urandom(), "R9 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule